// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register that either takes a whole byte from a parallel bus or moves its contents one place towards the last stage, feeding a new bit in at the first stage from a serial input. The last stage is driven out both as it is and inverted. Loading is controlled by an active-low level input: for as long as it is low, every stage follows its parallel bit, and any clock activity is disregarded.

Shifting is paced by two external clock lines whose logical OR forms the shift clock. Either line can carry a clock while the other is held low, or a line held high can inhibit clocking from the other. A line that rises while the other is low produces a shift exactly as a real clock edge would. The block itself runs on one free-running system clock. It brings all external inputs in through a synchronizer and finds rising edges of the OR of the synchronized clock lines.

Top module: `plso_shift_reg`

## Requirements
- R1: A synchronous active-high reset clears every stage and the edge history to 0, so after reset `q_last` is 0 and `q_last_n` is 1.
- R2: While `load_n` is low, stage k holds `par_in[k]`, so `q_last` equals `par_in[WIDTH-1]` (bit 7 by default), whatever either clock line does.
- R3: Changes on `par_in` made while `load_n` stays low are tracked by the stages; the load is a level, not a one-time capture.
- R4: With `load_n` high, each 0-to-1 transition of `ck_a | ck_b` shifts once: stage 0 takes `ser_in`, stage k takes the old stage k-1.
- R5: While one clock line is held high, transitions on the other line cause no shift.
- R6: A line that rises while the other line is low causes exactly one shift, including when it was meant as an inhibit.
- R7: `q_last_n` is always the inverse of `q_last`.
- R8: If the load goes low in the same synchronized cycle as a combined-clock rising edge, the load wins and no shift takes place.
- R9: Every input passes through `SYNC_STAGES` (default 2) system-clock flops. A change on an input before system edge n appears on the outputs after edge n+`SYNC_STAGES`, that is after the third edge by default, and not after the second.
- R10: `ser_in` is sampled only at a combined-clock rising edge; changing it while the combined clock stays high or low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load, active low, level-sensitive |
| ck_a | input | 1 | First external clock line |
| ck_b | input | 1 | Second external clock line |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel data, bit k to stage k |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Inverse of last stage |

## Verification
With the default of two synchronizer flops, a result is due three system edges after its input changed. A precise latency test shows the old value after two edges and the new value after the third. Every other stimulus holds its inputs for four system cycles and samples at the falling edge after that. An exhaustive sweep loads all 256 bytes and clocks out sixteen bits for each, alternating the clock lines and disturbing `ser_in` between edges. Directed sequences cover inhibit, the double-clock hazard, load tracking and load against a same-cycle edge.

// File: rtl/plso_pkg.sv
package plso_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_LOAD  = 2'd2
   } plso_op_e;

   // Load has priority over a detected edge.
   function automatic plso_op_e pick_op(input logic load_low, input logic edge_seen);
      if (load_low)       return OP_LOAD;
      else if (edge_seen) return OP_SHIFT;
      else                return OP_HOLD;
   endfunction

endpackage

// File: rtl/plso_sync.sv
module plso_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("plso_sync: WIDTH must be at least 1");
      end
      if (STAGES < 0) begin : g_bad_stages
         $error("plso_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe [STAGES];

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end

         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/plso_edge_det.sv
module plso_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic line_a,
   input  logic line_b,
   output logic rise
);

   logic merged;
   logic merged_prev;

   assign merged = line_a | line_b;

   always_ff @(posedge clk) begin
      if (rst) merged_prev <= 1'b0;
      else     merged_prev <= merged;
   end

   assign rise = merged & ~merged_prev;

   // A line held high across a cycle masks the other line.
   assert_inhibit_blocks_R5: assert property (@(posedge clk) disable iff (rst)
      (line_a && $past(line_a) && !$past(rst)) || (line_b && $past(line_b) && !$past(rst)) |-> !rise);

   // Each rise of the merged clock gives a single detected edge.
   assert_single_edge_R6: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/plso_stage_chain.sv
module plso_stage_chain
   import plso_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  plso_op_e         op,
   input  logic             din,
   input  logic [WIDTH-1:0] par,
   output logic [WIDTH-1:0] stages
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("plso_stage_chain: WIDTH must be at least 2");
      end

      for (genvar k = 0; k < WIDTH; k++) begin : g_stage
         logic feed;
         if (k == 0) begin : g_head
            assign feed = din;
         end else begin : g_body
            assign feed = stages[k-1];
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               stages[k] <= 1'b0;
            end else begin
               unique case (op)
                  OP_LOAD:  stages[k] <= par[k];
                  OP_SHIFT: stages[k] <= feed;
                  default:  stages[k] <= stages[k];
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/plso_shift_reg.sv
module plso_shift_reg
   import plso_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_n,
   input  logic             ck_a,
   input  logic             ck_b,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   output logic             q_last,
   output logic             q_last_n
);

   localparam int BUS_W = WIDTH + 4;
   // load_n rests high so reset does not look like a load request.
   localparam logic [BUS_W-1:0] BUS_RST = {{WIDTH{1'b0}}, 4'b1000};

   logic [BUS_W-1:0] bus_raw;
   logic [BUS_W-1:0] bus_s;
   logic             load_n_s;
   logic             ck_a_s;
   logic             ck_b_s;
   logic             ser_s;
   logic [WIDTH-1:0] par_s;
   logic             rise;
   plso_op_e         op;
   logic [WIDTH-1:0] stages;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("plso_shift_reg: WIDTH must be at least 2");
      end
   endgenerate

   assign bus_raw = {par_in, load_n, ck_a, ck_b, ser_in};

   plso_sync #(
      .WIDTH   (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (BUS_RST)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (bus_raw),
      .q   (bus_s)
   );

   assign par_s    = bus_s[BUS_W-1:4];
   assign load_n_s = bus_s[3];
   assign ck_a_s   = bus_s[2];
   assign ck_b_s   = bus_s[1];
   assign ser_s    = bus_s[0];

   plso_edge_det u_edge (
      .clk    (clk),
      .rst    (rst),
      .line_a (ck_a_s),
      .line_b (ck_b_s),
      .rise   (rise)
   );

   assign op = pick_op(~load_n_s, rise);

   plso_stage_chain #(
      .WIDTH (WIDTH)
   ) u_chain (
      .clk    (clk),
      .rst    (rst),
      .op     (op),
      .din    (ser_s),
      .par    (par_s),
      .stages (stages)
   );

   assign q_last   = stages[WIDTH-1];
   assign q_last_n = ~stages[WIDTH-1];

   // Load level overrides a same-cycle edge (R2, R8).
   assert_load_follows_R2: assert property (@(posedge clk) disable iff (rst)
      !load_n_s |=> stages == $past(par_s));

   // A detected edge with load high moves every stage one place.
   assert_shift_step_R4: assert property (@(posedge clk) disable iff (rst)
      load_n_s && rise |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_s)});

   // Without an edge, serial data is not looked at and nothing moves.
   assert_hold_no_edge_R10: assert property (@(posedge clk) disable iff (rst)
      load_n_s && !rise |=> $stable(stages));

   // Output pair stays complementary at every sample.
   assert_outputs_complement_R7: assert property (@(posedge clk) disable iff (rst)
      q_last_n != q_last);

endmodule

// File: tb/sim_plso_shift_reg.sv
module sim_plso_shift_reg;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 200000;

   logic       clk = 1'b0;
   logic       rst;
   logic       load_n;
   logic       ck_a;
   logic       ck_b;
   logic       ser_in;
   logic [7:0] par_in;
   logic       q_last;
   logic       q_last_n;

   int   checks = 0;
   int   errors = 0;
   logic [7:0] model;
   logic       done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   plso_shift_reg #(.WIDTH(8), .SYNC_STAGES(2)) u0 (
      .clk      (clk),
      .rst      (rst),
      .load_n   (load_n),
      .ck_a     (ck_a),
      .ck_b     (ck_b),
      .ser_in   (ser_in),
      .par_in   (par_in),
      .q_last   (q_last),
      .q_last_n (q_last_n)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_bit(input logic exp, input string tag);
      checks++;
      if (q_last !== exp || q_last_n !== ~exp) begin
         errors++;
         $display("FAIL %s/R7: q_last=%b q_last_n=%b expected %b/%b",
                  tag, q_last, q_last_n, exp, ~exp);
      end
   endtask

   // Drive all inputs at a falling edge, update the model, wait past latency.
   task automatic apply(input logic ln, input logic a, input logic b,
                        input logic s, input logic [7:0] p, input string tag);
      logic rise_c;
      rise_c = (a | b) && !(ck_a | ck_b);
      load_n = ln; ck_a = a; ck_b = b; ser_in = s; par_in = p;
      if (!ln)        model = p;
      else if (rise_c) model = {model[6:0], s};
      step(4);
      check_bit(model[7], tag);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; load_n = 1'b1; ck_a = 1'b0; ck_b = 1'b0;
      ser_in = 1'b0; par_in = 8'h00; model = 8'h00;
      step(3);
      rst = 1'b0;
      step(4);
      check_bit(1'b0, "R1 reset state");

      // R9: exact latency of a load change
      apply(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R2 load zero");
      par_in = 8'h80;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_bit(1'b0, "R9 old value after two edges");
      @(posedge clk);
      @(negedge clk);
      check_bit(1'b1, "R9 new value after third edge");
      model = 8'h80;
      step(2);

      // R3: tracking while load stays low, clocks toggling (R2)
      apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h01, "R3 track");
      apply(1'b0, 1'b0, 1'b0, 1'b0, 8'hF0, "R3 track");
      apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h7F, "R2 clock ignored");
      apply(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, "R3 track");
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, "R2 release");

      // R5: hold ck_a high, toggle ck_b; then the reverse
      apply(1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, "R4 shift via a");
      for (int i = 0; i < 3; i++) begin
         apply(1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, "R5 b masked");
         apply(1'b1, 1'b1, 1'b0, 1'b1, 8'hA5, "R5 b masked");
      end
      apply(1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, "R5 both high");
      for (int i = 0; i < 3; i++) begin
         apply(1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, "R5 a masked");
         apply(1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, "R5 a masked");
      end
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, "R5 release");

      // R6: inhibit rising while other line low shifts once
      apply(1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, "R6 double clock");
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, "R6 fall");
      apply(1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, "R6 double clock a");
      apply(1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, "R6 fall");
      for (int i = 0; i < 8; i++) begin
         apply(1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, "R4 drain");
         apply(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, "R4 drain");
      end

      // R8: load falls with a clock rise in the same cycle
      apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, "R8 load beats edge");
      apply(1'b1, 1'b1, 1'b0, 1'b1, 8'h3C, "R8 release");
      for (int i = 0; i < 8; i++) begin
         apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, "R8 readout");
         apply(1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, "R8 readout");
      end
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, "R4 idle");

      // Exhaustive sweep over all bytes: load, then sixteen shifts
      for (int v = 0; v < 256; v++) begin
         apply(1'b0, 1'b0, 1'b0, 1'b0, v[7:0], "R2 sweep load");
         apply(1'b1, 1'b0, 1'b0, 1'b0, v[7:0], "R2 sweep release");
         for (int i = 0; i < 16; i++) begin
            logic s;
            logic use_a;
            s = v[i % 8] ^ (i >= 8);
            use_a = (i % 2 == 0);
            apply(1'b1, use_a, !use_a, s, v[7:0], "R4 sweep shift");
            apply(1'b1, use_a, !use_a, !s, v[7:0], "R10 serial change high");
            apply(1'b1, 1'b0, 1'b0, s, v[7:0], "R10 serial change low");
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule